// File: doc/BRIEF.md
# TCP Session Payload Follower

A receive-only filter that watches a raw Ethernet II byte stream, one byte per clock, and walks the Ethernet, IPv4 and TCP headers of each frame as they pass. The frame is compared against one configured connection tuple: source IPv4 address, destination IPv4 address, source TCP port and destination TCP port. Only the TCP data bytes of frames that belong to that connection come out, each with a valid strobe. Header bytes, option bytes and Ethernet padding never appear at the output.

The block never stalls its input and never produces traffic of its own. It is placed on a tap of a receive path so that downstream logic sees the byte stream of one TCP connection in one direction. A match flag tells downstream logic that the frame now passing has been identified as part of the selected connection.

Top module: `tcp_follow`

## Requirements
- R1: While rst_ni is low, and at the first sample after reset, pay_valid_o and match_o are 0.
- R2: For a frame that passes every check, each TCP data byte is presented on pay_data_o with pay_valid_o high in the cycle after its input byte is accepted, in arrival order, with no byte lost or repeated.
- R3: A frame whose bytes 12 and 13 (the EtherType, high byte first) are not 0x08 then 0x00 produces no output and leaves match_o low.
- R4: A frame whose IPv4 protocol byte (IP header offset 9, where the IP header starts at frame byte 14) is not 6 produces no output and leaves match_o low.
- R5: A frame produces output only when the source address (IP offsets 12..15), destination address (IP offsets 16..19), source port (TCP offsets 0..1) and destination port (TCP offsets 2..3) all equal cfg_src_ip_i, cfg_dst_ip_i, cfg_src_port_i and cfg_dst_port_i; every multi-byte field is sent most significant byte first.
- R6: The TCP header starts at IP offset 4 × IHL, where IHL is the low nibble of IP offset 0; IP option bytes are never output.
- R7: TCP data starts at TCP offset 4 × data offset, where data offset is the high nibble of TCP offset 12; TCP option bytes are never output.
- R8: Output stops after IP offset total_length − 1, with total_length read from IP offsets 2..3; Ethernet padding after that point is never output.
- R9: No output follows the input byte that carries rx_eof_i until a new start of frame arrives, even if the frame was cut short; match_o keeps its value until then.
- R10: A byte with rx_sof_i high restarts parsing at frame byte 0, abandoning any frame in progress, and match_o is 0 in the following cycle.
- R11: match_o rises in the cycle after the destination port low byte when all checks so far passed, and pay_valid_o is never high while match_o is low.
- R12: A frame with IHL below 5 or TCP data offset below 5 produces no output, and a data offset below 5 drops match_o.
- R13: Input cycles with rx_valid_i low do not advance the parse, and valid bytes arriving outside a frame (after an end of frame and before the next start) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Frame byte |
| rx_valid_i | input | 1 | rx_data_i carries a byte this cycle |
| rx_sof_i | input | 1 | This byte is the first byte of a frame |
| rx_eof_i | input | 1 | This byte is the last byte of a frame |
| cfg_src_ip_i | input | 32 | Selected source IPv4 address |
| cfg_dst_ip_i | input | 32 | Selected destination IPv4 address |
| cfg_src_port_i | input | 16 | Selected source TCP port |
| cfg_dst_port_i | input | 16 | Selected destination TCP port |
| pay_data_o | output | 8 | TCP data byte |
| pay_valid_o | output | 1 | pay_data_o holds a data byte of the selected connection |
| match_o | output | 1 | Current frame identified as part of the selected connection |

## Verification
A corrupt byte position or header-length register shows up at the ports as data bytes that are shifted, missing or replaced by header or padding bytes, visible in the very first output cycle of the affected frame. A stuck pass/fail flag shows as a whole frame emitted or suppressed wrongly, and as a wrong match_o level in the cycle after the destination port. A frame-boundary error shows as output after an end of frame, or as match_o surviving a new start of frame by one cycle.

// File: rtl/tcp_follow_pkg.sv
package tcp_follow_pkg;
  localparam int unsigned ETH_HDR_LEN   = 14;
  localparam logic [15:0] ETYPE_IPV4    = 16'h0800;
  localparam logic [7:0]  PROTO_TCP     = 8'd6;
  localparam int unsigned IP_LEN_OFS    = 2;
  localparam int unsigned IP_PROTO_OFS  = 9;
  localparam int unsigned IP_SRC_OFS    = 12;
  localparam int unsigned IP_DST_OFS    = 16;
  localparam int unsigned TCP_DOFF_OFS  = 12;
  localparam logic [3:0]  MIN_HDR_WORDS = 4'd5;

  function automatic logic [7:0] be_byte32(input logic [31:0] w, input logic [1:0] idx);
    return w[(3 - idx) * 8 +: 8];
  endfunction

  function automatic logic [7:0] be_byte16(input logic [15:0] w, input logic idx);
    return idx ? w[7:0] : w[15:8];
  endfunction
endpackage

// File: rtl/tcp_follow_pos.sv
module tcp_follow_pos #(
  parameter int unsigned POS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             byte_en_o,
  output logic [POS_W-1:0] pos_o
);
  logic             in_frame_q;
  logic [POS_W-1:0] pos_q;

  assign byte_en_o = valid_i & (sof_i | in_frame_q);
  assign pos_o     = sof_i ? '0 : pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      pos_q      <= '0;
    end else if (byte_en_o) begin
      in_frame_q <= ~eof_i;
      // saturate so oversized frames cannot alias onto header offsets
      pos_q      <= (pos_o == '1) ? pos_o : pos_o + 1'b1;
    end
  end
endmodule

// File: rtl/tcp_follow_hdr.sv
module tcp_follow_hdr
  import tcp_follow_pkg::*;
#(
  parameter int unsigned POS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_en_i,
  input  logic             sof_en_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       data_i,
  input  logic [31:0]      cfg_src_ip_i,
  input  logic [31:0]      cfg_dst_ip_i,
  input  logic [15:0]      cfg_src_port_i,
  input  logic [15:0]      cfg_dst_port_i,
  output logic             ok_o,
  output logic             tuple_done_o,
  output logic             is_pay_o
);
  localparam int unsigned      CW      = (POS_W > 16) ? POS_W : 16;
  localparam logic [POS_W-1:0] IP_BASE = POS_W'(ETH_HDR_LEN);
  localparam logic [POS_W-1:0] ET_HI   = POS_W'(ETH_HDR_LEN - 2);
  localparam logic [POS_W-1:0] ET_LO   = POS_W'(ETH_HDR_LEN - 1);
  localparam logic [POS_W-1:0] LEN_HI  = POS_W'(IP_LEN_OFS);
  localparam logic [POS_W-1:0] LEN_LO  = POS_W'(IP_LEN_OFS + 1);
  localparam logic [POS_W-1:0] PROTO_P = POS_W'(IP_PROTO_OFS);
  localparam logic [POS_W-1:0] SRC_P   = POS_W'(IP_SRC_OFS);
  localparam logic [POS_W-1:0] DST_P   = POS_W'(IP_DST_OFS);
  localparam logic [POS_W-1:0] DST_END = POS_W'(IP_DST_OFS + 4);
  localparam logic [POS_W-1:0] DOFF_P  = POS_W'(TCP_DOFF_OFS);

  logic             ok_q, doff_seen_q;
  logic [3:0]       ihl_q, doff_q;
  logic [15:0]      tot_len_q;
  logic [POS_W-1:0] ip_rel, tcp_base, tcp_rel, pay_start;
  logic             past_ip, in_tcp, bad;

  assign ip_rel    = pos_i - IP_BASE;
  assign past_ip   = pos_i > IP_BASE;
  assign tcp_base  = IP_BASE + POS_W'({ihl_q, 2'b00});
  assign in_tcp    = past_ip && (pos_i >= tcp_base);
  assign tcp_rel   = pos_i - tcp_base;
  assign pay_start = POS_W'({doff_q, 2'b00});

  always_comb begin
    bad = 1'b0;
    if (pos_i == ET_HI) bad = (data_i != ETYPE_IPV4[15:8]);
    if (pos_i == ET_LO) bad = (data_i != ETYPE_IPV4[7:0]);
    if (pos_i == IP_BASE) bad = (data_i[3:0] < MIN_HDR_WORDS);
    if (past_ip) begin
      if (ip_rel == PROTO_P) bad = (data_i != PROTO_TCP);
      if (ip_rel >= SRC_P && ip_rel < DST_P)
        bad = (data_i != be_byte32(cfg_src_ip_i, ip_rel[1:0]));
      if (ip_rel >= DST_P && ip_rel < DST_END)
        bad = (data_i != be_byte32(cfg_dst_ip_i, ip_rel[1:0]));
    end
    if (in_tcp) begin
      if (tcp_rel < POS_W'(2))       bad = (data_i != be_byte16(cfg_src_port_i, tcp_rel[0]));
      else if (tcp_rel < POS_W'(4))  bad = (data_i != be_byte16(cfg_dst_port_i, tcp_rel[0]));
      else if (tcp_rel == DOFF_P)    bad = (data_i[7:4] < MIN_HDR_WORDS);
    end
  end

  assign ok_o         = (sof_en_i | ok_q) & ~bad;
  assign tuple_done_o = in_tcp && (tcp_rel == POS_W'(3));
  assign is_pay_o     = ok_o && doff_seen_q && in_tcp && (tcp_rel >= pay_start)
                        && (CW'(ip_rel) < CW'(tot_len_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q        <= 1'b0;
      doff_seen_q <= 1'b0;
      ihl_q       <= '0;
      doff_q      <= '0;
      tot_len_q   <= '0;
    end else if (byte_en_i) begin
      ok_q <= ok_o;
      if (sof_en_i) doff_seen_q <= 1'b0;
      if (pos_i == IP_BASE) ihl_q <= data_i[3:0];
      if (past_ip && ip_rel == LEN_HI) tot_len_q[15:8] <= data_i;
      if (past_ip && ip_rel == LEN_LO) tot_len_q[7:0]  <= data_i;
      if (in_tcp && tcp_rel == DOFF_P) begin
        doff_q      <= data_i[7:4];
        doff_seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcp_follow_gate.sv
module tcp_follow_gate (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_en_i,
  input  logic       sof_en_i,
  input  logic [7:0] data_i,
  input  logic       ok_i,
  input  logic       tuple_done_i,
  input  logic       is_pay_i,
  output logic [7:0] pay_data_o,
  output logic       pay_valid_o,
  output logic       match_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pay_data_o  <= '0;
      pay_valid_o <= 1'b0;
      match_o     <= 1'b0;
    end else begin
      pay_valid_o <= byte_en_i & is_pay_i;
      if (byte_en_i & is_pay_i) pay_data_o <= data_i;
      if (byte_en_i)
        match_o <= sof_en_i ? 1'b0 : ((match_o | tuple_done_i) & ok_i);
    end
  end
endmodule

// File: rtl/tcp_follow.sv
module tcp_follow #(
  parameter int unsigned POS_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic [31:0] cfg_src_ip_i,
  input  logic [31:0] cfg_dst_ip_i,
  input  logic [15:0] cfg_src_port_i,
  input  logic [15:0] cfg_dst_port_i,
  output logic [7:0]  pay_data_o,
  output logic        pay_valid_o,
  output logic        match_o
);
  logic             byte_en, sof_en, ok, tuple_done, is_pay;
  logic [POS_W-1:0] pos;

  assign sof_en = byte_en & rx_sof_i;

  tcp_follow_pos #(.POS_W(POS_W)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(rx_valid_i), .sof_i(rx_sof_i),
    .eof_i(rx_eof_i), .byte_en_o(byte_en), .pos_o(pos)
  );

  tcp_follow_hdr #(.POS_W(POS_W)) u_hdr (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_en_i(byte_en), .sof_en_i(sof_en),
    .pos_i(pos), .data_i(rx_data_i), .cfg_src_ip_i(cfg_src_ip_i),
    .cfg_dst_ip_i(cfg_dst_ip_i), .cfg_src_port_i(cfg_src_port_i),
    .cfg_dst_port_i(cfg_dst_port_i), .ok_o(ok), .tuple_done_o(tuple_done),
    .is_pay_o(is_pay)
  );

  tcp_follow_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_en_i(byte_en), .sof_en_i(sof_en),
    .data_i(rx_data_i), .ok_i(ok), .tuple_done_i(tuple_done), .is_pay_i(is_pay),
    .pay_data_o(pay_data_o), .pay_valid_o(pay_valid_o), .match_o(match_o)
  );
endmodule

// File: rtl/tcp_follow_chk.sv
module tcp_follow_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic rx_sof_i,
  input logic rx_eof_i,
  input logic pay_valid_o,
  input logic match_o
);
  p_pay_needs_match_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_o |-> match_o);

  p_match_rise_on_byte_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> $past(rx_valid_i));

  p_pay_needs_byte_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_o |-> $past(rx_valid_i));

  p_sof_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_sof_i) |=> (!pay_valid_o && !match_o));

  p_quiet_after_eof_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rx_valid_i && rx_eof_i) && !(rx_valid_i && rx_sof_i)) |=> !pay_valid_o);
endmodule

bind tcp_follow tcp_follow_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_sof_i(rx_sof_i),
  .rx_eof_i(rx_eof_i), .pay_valid_o(pay_valid_o), .match_o(match_o)
);

// File: tb/tcp_follow_tb.sv
module tcp_follow_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SIP = 32'hC0A8_0A05;
  localparam logic [31:0] DIP = 32'h0A00_0117;
  localparam logic [15:0] SP  = 16'hD431;
  localparam logic [15:0] DP  = 16'h01BB;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  pay_data;
  logic        pay_valid, match;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tcp_follow u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .cfg_src_ip_i(SIP), .cfg_dst_ip_i(DIP),
    .cfg_src_port_i(SP), .cfg_dst_port_i(DP), .pay_data_o(pay_data),
    .pay_valid_o(pay_valid), .match_o(match)
  );

  typedef struct {
    logic [31:0] sip, dip;
    logic [15:0] sp, dp, etype;
    logic [7:0]  proto, seed;
    int          ihl, doff, plen, pad, cut;
    bit          no_eof, gaps, emit, mtch;
  } frm_t;

  int         n_cmp = 0, n_bad = 0, n_out = 0;
  logic [7:0] exp_q[$];
  logic [7:0] e;
  string      cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare each emitted byte
  always @(negedge clk) begin
    if (rst_n && pay_valid) begin
      n_out++;
      if (exp_q.size() == 0) chk(1'b0, {cur_req, " unexpected byte"}, pay_data, 0);
      else begin
        e = exp_q.pop_front();
        chk(pay_data == e, cur_req, pay_data, e);
      end
    end
  end

  function automatic frm_t good(input int plen, input logic [7:0] seed);
    frm_t f;
    f.sip = SIP; f.dip = DIP; f.sp = SP; f.dp = DP; f.etype = 16'h0800;
    f.proto = 8'd6; f.seed = seed; f.ihl = 5; f.doff = 5; f.plen = plen;
    f.pad = 0; f.cut = -1; f.no_eof = 0; f.gaps = 0; f.emit = 1; f.mtch = 1;
    return f;
  endfunction

  task automatic send(input frm_t f, input string req);
    logic [7:0] b[$];
    int tot, hl, n;
    cur_req = req;
    tot = f.ihl * 4 + f.doff * 4 + f.plen;
    for (int i = 0; i < 12; i++) b.push_back(8'h10 + 8'(i));
    b.push_back(f.etype[15:8]); b.push_back(f.etype[7:0]);
    b.push_back({4'h4, 4'(f.ihl)}); b.push_back(8'h00);
    b.push_back(8'(tot >> 8)); b.push_back(8'(tot));
    b.push_back(8'h12); b.push_back(8'h34); b.push_back(8'h40); b.push_back(8'h00);
    b.push_back(8'h40); b.push_back(f.proto); b.push_back(8'h00); b.push_back(8'h00);
    for (int i = 0; i < 4; i++) b.push_back(f.sip[31 - 8 * i -: 8]);
    for (int i = 0; i < 4; i++) b.push_back(f.dip[31 - 8 * i -: 8]);
    for (int i = 0; i < (f.ihl - 5) * 4; i++) b.push_back(8'hA0 + 8'(i));
    b.push_back(f.sp[15:8]); b.push_back(f.sp[7:0]);
    b.push_back(f.dp[15:8]); b.push_back(f.dp[7:0]);
    for (int i = 0; i < 8; i++) b.push_back(8'h50 + 8'(i));
    b.push_back({4'(f.doff), 4'h0}); b.push_back(8'h18);
    for (int i = 0; i < 6; i++) b.push_back(8'hE0 + 8'(i));
    for (int i = 0; i < (f.doff - 5) * 4; i++) b.push_back(8'hC0 + 8'(i));
    hl = b.size();
    for (int j = 0; j < f.plen; j++) begin
      b.push_back(f.seed + 8'(j * 7));
      if (f.emit && (f.cut < 0 || hl + j < f.cut)) exp_q.push_back(f.seed + 8'(j * 7));
    end
    for (int j = 0; j < f.pad; j++) b.push_back(8'h00);
    n = (f.cut < 0) ? b.size() : f.cut;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 1) chk(match == 1'b0, "R11/R10 match cleared after sof", match, 0);
      if (f.gaps && (i % 4 == 2)) begin
        rx_valid = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1; rx_data = b[i];
      rx_sof = (i == 0); rx_eof = (i == n - 1) && !f.no_eof;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    if (!f.no_eof) begin
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, {req, " bytes missing"}, exp_q.size(), 0);
      chk(match == f.mtch, {req, " match level"}, match, f.mtch);
      exp_q.delete();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    frm_t f;
    int   snap;
    rst_n = 1'b0; rx_data = '0; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (3) @(negedge clk);
    chk(pay_valid == 1'b0 && match == 1'b0, "R1 reset outputs", {pay_valid, match}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pay_valid == 1'b0 && match == 1'b0, "R1 after reset", {pay_valid, match}, 0);

    send(good(10, 8'h31), "R2 basic payload");
    f = good(0, 8'h00); send(f, "R11 empty payload keeps match");
    f = good(7, 8'h82); f.gaps = 1; send(f, "R13 gaps between bytes");
    f = good(6, 8'h11); f.etype = 16'h86DD; f.emit = 0; f.mtch = 0; send(f, "R3 non-IPv4 ethertype");
    f = good(6, 8'h12); f.proto = 8'd17; f.emit = 0; f.mtch = 0; send(f, "R4 non-TCP protocol");
    f = good(6, 8'h13); f.sip[0] = ~f.sip[0]; f.emit = 0; f.mtch = 0; send(f, "R5 source ip mismatch");
    f = good(6, 8'h14); f.dip[31] = ~f.dip[31]; f.emit = 0; f.mtch = 0; send(f, "R5 dest ip mismatch");
    f = good(6, 8'h15); f.sp[8] = ~f.sp[8]; f.emit = 0; f.mtch = 0; send(f, "R5 source port mismatch");
    f = good(6, 8'h16); f.dp[0] = ~f.dp[0]; f.emit = 0; f.mtch = 0; send(f, "R5 dest port mismatch");
    f = good(5, 8'h40); f.ihl = 7; send(f, "R6 ip options skipped");
    f = good(6, 8'h50); f.doff = 8; send(f, "R7 tcp options skipped");
    f = good(3, 8'h60); f.pad = 9; send(f, "R8 padding suppressed");
    f = good(6, 8'h70); f.ihl = 4; f.emit = 0; f.mtch = 0; send(f, "R12 short ihl");
    f = good(6, 8'h71); f.doff = 4; f.emit = 0; f.mtch = 0; send(f, "R12 short data offset");
    f = good(20, 8'h90); f.cut = 62; send(f, "R9 truncated frame");

    // stray valid bytes outside any frame
    snap = n_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'h08 + 8'(i); rx_sof = 1'b0; rx_eof = 1'b0;
    end
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(n_out == snap, "R13 bytes outside frame ignored", n_out - snap, 0);
    chk(match == 1'b1, "R9 match held after eof", match, 1);

    f = good(30, 8'hA0); f.cut = 40; f.no_eof = 1; send(f, "R10 abandoned frame");
    send(good(9, 8'hB0), "R10 restart on sof");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule